// File: doc/BRIEF.md
# Sector Header Validity Judge

This block gives the verdict on each received data sector once its decode pass has finished. It does not compute CRC, EDC or ECC. It takes the four header bytes captured at the start of the sector (minute, second and frame in BCD, then the mode byte) and the two sync-framing error flags, and decides whether the sector is good or bad. It then updates a small set of error-status outputs.

A one-cycle `dec_done` strobe starts the evaluation. The results appear on the outputs on the following clock edge and stay there. A one-cycle `blk_start` strobe marks the arrival of the next sector. It clears the per-sector error flags but leaves the two status bytes alone. The flag outputs are sticky: a second decode completion before the next block start ORs its flags into the ones already set.

Top module: `sector_hdr_judge`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, `crc_ok`, `uncorr_blk` and `word_long` are 0, and `stat1` and `stat2` are 8'h00.
- R2: A sector is judged good only if every one of these holds: `hdr_min` < 8'h74, `hdr_sec` < 8'h60, `hdr_frm` < 8'h75, and the low nibble (bits 3:0) of each of these three bytes is below 4'hA.
- R3: A sector is also judged good only if `hdr_mode` < 3 and both `sync_missing` and `sync_illegal` are low in the `dec_done` cycle. Otherwise it is judged bad.
- R4: After a good verdict, `stat1` is 8'h00 and `stat2` is 8'h90 from the edge on which `dec_done` is sampled.
- R5: After a bad verdict, `stat1` is 8'hFF and `stat2` is 8'hF2 from that same edge.
- R6: A good verdict sets `crc_ok` only when `req_bits` (bit 1 or bit 0) is nonzero. When `req_bits` is 0, `crc_ok` is left unchanged.
- R7: A bad verdict sets `uncorr_blk` only when `req_bits` is nonzero. When `req_bits` is 0, `uncorr_blk` is left unchanged.
- R8: Every `dec_done` sets `word_long`, whatever the verdict.
- R9: `blk_start` without `dec_done` clears `crc_ok`, `uncorr_blk` and `word_long` on the next edge. `stat1` and `stat2` keep their values.
- R10: When neither strobe is high, every output holds. Flags set by successive decode completions accumulate until the next `blk_start`.
- R11: When `blk_start` and `dec_done` are high in the same cycle, the clear is applied first and the new verdict afterwards. Flags set earlier are dropped and only the new ones remain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_start | input | 1 | One-cycle strobe: a new sector begins |
| dec_done | input | 1 | One-cycle strobe: decode complete, evaluate the header |
| hdr_min | input | 8 | Header byte 0, BCD minute |
| hdr_sec | input | 8 | Header byte 1, BCD second |
| hdr_frm | input | 8 | Header byte 2, BCD frame |
| hdr_mode | input | 8 | Header byte 3, sector mode |
| sync_missing | input | 1 | The sync for this sector was inserted, not detected |
| sync_illegal | input | 1 | The sync was detected at an unexpected position |
| req_bits | input | 2 | Output and processing request bits of the decoder control |
| crc_ok | output | 1 | Good-sector flag |
| uncorr_blk | output | 1 | Uncorrectable-sector flag |
| stat1 | output | 8 | Status byte 1 |
| stat2 | output | 8 | Status byte 2 |
| word_long | output | 1 | Decode-completion flag |

## Verification
The hardest state to reach is the one where both `crc_ok` and `uncorr_blk` are set at once. It exists only when two decode completions of opposite verdict arrive with no block start between them. The stimulus makes exactly that sequence. It then raises both strobes together to show that this doubled state collapses to the new verdict alone. The header limits are each tested from both sides, one step apart: the byte equal to its limit, the byte one below, and a low nibble of A. Each is tested on its own with the other fields valid, so a wrong comparison in any one field shows up alone.

// File: rtl/sector_hdr_judge.sv
module sector_hdr_judge #(
  parameter int          BW        = 8,
  parameter logic [7:0]  MIN_LIM   = 8'h74,
  parameter logic [7:0]  SEC_LIM   = 8'h60,
  parameter logic [7:0]  FRM_LIM   = 8'h75,
  parameter logic [7:0]  MODE_LIM  = 8'h03,
  parameter logic [7:0]  GOOD_S1   = 8'h00,
  parameter logic [7:0]  GOOD_S2   = 8'h90,
  parameter logic [7:0]  BAD_S1    = 8'hFF,
  parameter logic [7:0]  BAD_S2    = 8'hF2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_start,
  input  logic          dec_done,
  input  logic [BW-1:0] hdr_min,
  input  logic [BW-1:0] hdr_sec,
  input  logic [BW-1:0] hdr_frm,
  input  logic [BW-1:0] hdr_mode,
  input  logic          sync_missing,
  input  logic          sync_illegal,
  input  logic [1:0]    req_bits,
  output logic          crc_ok,
  output logic          uncorr_blk,
  output logic [BW-1:0] stat1,
  output logic [BW-1:0] stat2,
  output logic          word_long
);

  localparam logic [3:0] DIGIT_LIM = 4'hA;

  function automatic logic bcd_in_range(input logic [BW-1:0] b, input logic [BW-1:0] lim);
    return (b < lim) && (b[3:0] < DIGIT_LIM);
  endfunction

  logic addr_ok, frame_ok, good, req_any;

  assign addr_ok  = bcd_in_range(hdr_min, MIN_LIM) &&
                    bcd_in_range(hdr_sec, SEC_LIM) &&
                    bcd_in_range(hdr_frm, FRM_LIM);
  assign frame_ok = (hdr_mode < MODE_LIM) && !sync_missing && !sync_illegal;
  assign good     = addr_ok && frame_ok;
  assign req_any  = |req_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_ok     <= 1'b0;
      uncorr_blk <= 1'b0;
      word_long  <= 1'b0;
      stat1      <= '0;
      stat2      <= '0;
    end else begin
      if (blk_start) begin
        crc_ok     <= 1'b0;
        uncorr_blk <= 1'b0;
        word_long  <= 1'b0;
      end
      if (dec_done) begin
        word_long <= 1'b1;
        if (good) begin
          if (req_any) crc_ok <= 1'b1;
          stat1 <= GOOD_S1;
          stat2 <= GOOD_S2;
        end else begin
          if (req_any) uncorr_blk <= 1'b1;
          stat1 <= BAD_S1;
          stat2 <= BAD_S2;
        end
      end
    end
  end

  AST_WL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done |=> word_long); // R8
  AST_MODE_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done && (hdr_mode >= MODE_LIM) |=> (stat1 == BAD_S1) && (stat2 == BAD_S2)); // R3
  AST_SYNC_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done && (sync_missing || sync_illegal) |=> (stat2 == BAD_S2)); // R3
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start && !dec_done |=> !crc_ok && !uncorr_blk && !word_long && $stable(stat1) && $stable(stat2)); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_start && !dec_done |=> $stable(stat1) && $stable(stat2) && $stable(crc_ok) && $stable(uncorr_blk)); // R10
  AST_BOTH_NOREQ: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start && dec_done && (req_bits == 2'b00) |=> !crc_ok && !uncorr_blk); // R11
  AST_NO_DOUBLE_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |=> !(crc_ok && uncorr_blk)); // R11

endmodule

// File: tb/sector_hdr_judge_tb.sv
module sector_hdr_judge_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       blk_start = 1'b0, dec_done = 1'b0;
  logic [7:0] hdr_min = '0, hdr_sec = '0, hdr_frm = '0, hdr_mode = '0;
  logic       sync_missing = 1'b0, sync_illegal = 1'b0;
  logic [1:0] req_bits = '0;
  logic       crc_ok, uncorr_blk, word_long;
  logic [7:0] stat1, stat2;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sector_hdr_judge dut_i (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .dec_done(dec_done),
    .hdr_min(hdr_min), .hdr_sec(hdr_sec), .hdr_frm(hdr_frm), .hdr_mode(hdr_mode),
    .sync_missing(sync_missing), .sync_illegal(sync_illegal), .req_bits(req_bits),
    .crc_ok(crc_ok), .uncorr_blk(uncorr_blk), .stat1(stat1), .stat2(stat2),
    .word_long(word_long)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive one cycle of strobes at negedge, then return at the next negedge
  task automatic pulse(input logic st, input logic dd, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] c, input logic [7:0] m, input logic ms, input logic il,
                       input logic [1:0] rq);
    @(negedge clk);
    blk_start = st; dec_done = dd;
    hdr_min = a; hdr_sec = b; hdr_frm = c; hdr_mode = m;
    sync_missing = ms; sync_illegal = il; req_bits = rq;
    @(negedge clk);
    blk_start = 0; dec_done = 0;
  endtask

  task automatic new_block();
    pulse(1, 0, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 2'b00);
  endtask

  task automatic verdict(input string req, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] c, input logic [7:0] m, input logic ms,
                         input logic il, input bit exp_good);
    new_block();
    pulse(0, 1, a, b, c, m, ms, il, 2'b11);
    chk(req, "stat1", stat1, exp_good ? 8'h00 : 8'hFF);
    chk(req, "stat2", stat2, exp_good ? 8'h90 : 8'hF2);
    chk(req, "crc_ok", {7'd0, crc_ok}, {7'd0, exp_good});
    chk(req, "uncorr", {7'd0, uncorr_blk}, {7'd0, !exp_good});
  endtask

  task automatic t_reset();
    chk("R1", "crc_ok", {7'd0, crc_ok}, 8'd0);
    chk("R1", "uncorr", {7'd0, uncorr_blk}, 8'd0);
    chk("R1", "word_long", {7'd0, word_long}, 8'd0);
    chk("R1", "stat1", stat1, 8'h00);
    chk("R1", "stat2", stat2, 8'h00);
  endtask

  task automatic t_good_req();
    pulse(0, 1, 8'h12, 8'h34, 8'h56, 8'h01, 0, 0, 2'b10);
    chk("R4", "stat1", stat1, 8'h00);
    chk("R4", "stat2", stat2, 8'h90);
    chk("R6", "crc_ok", {7'd0, crc_ok}, 8'd1);
    chk("R8", "word_long", {7'd0, word_long}, 8'd1);
  endtask

  task automatic t_clear();
    new_block();
    chk("R9", "crc_ok", {7'd0, crc_ok}, 8'd0);
    chk("R9", "word_long", {7'd0, word_long}, 8'd0);
    chk("R9", "stat2", stat2, 8'h90);
  endtask

  task automatic t_noreq();
    pulse(0, 1, 8'h01, 8'h02, 8'h03, 8'h02, 0, 0, 2'b00);
    chk("R6", "crc_ok", {7'd0, crc_ok}, 8'd0);
    chk("R8", "word_long", {7'd0, word_long}, 8'd1);
    new_block();
    pulse(0, 1, 8'h80, 8'h02, 8'h03, 8'h02, 0, 0, 2'b00);
    chk("R7", "uncorr", {7'd0, uncorr_blk}, 8'd0);
    chk("R5", "stat1", stat1, 8'hFF);
    chk("R8", "word_long", {7'd0, word_long}, 8'd1);
    new_block();
    pulse(0, 1, 8'h80, 8'h02, 8'h03, 8'h02, 0, 0, 2'b01);
    chk("R7", "uncorr", {7'd0, uncorr_blk}, 8'd1);
    chk("R7", "crc_ok", {7'd0, crc_ok}, 8'd0);
  endtask

  task automatic t_limits();
    verdict("R2", 8'h73, 8'h59, 8'h74, 8'h00, 0, 0, 1);
    verdict("R2", 8'h74, 8'h00, 8'h00, 8'h00, 0, 0, 0);
    verdict("R2", 8'h1A, 8'h00, 8'h00, 8'h00, 0, 0, 0);
    verdict("R2", 8'h00, 8'h60, 8'h00, 8'h00, 0, 0, 0);
    verdict("R2", 8'h00, 8'h0B, 8'h00, 8'h00, 0, 0, 0);
    verdict("R2", 8'h00, 8'h00, 8'h75, 8'h00, 0, 0, 0);
    verdict("R2", 8'h00, 8'h00, 8'h0A, 8'h00, 0, 0, 0);
  endtask

  task automatic t_mode_sync();
    verdict("R3", 8'h00, 8'h02, 8'h00, 8'h02, 0, 0, 1);
    verdict("R3", 8'h00, 8'h02, 8'h00, 8'h03, 0, 0, 0);
    verdict("R3", 8'h00, 8'h02, 8'h00, 8'h01, 1, 0, 0);
    verdict("R3", 8'h00, 8'h02, 8'h00, 8'h01, 0, 1, 0);
  endtask

  task automatic t_sticky();
    new_block();
    pulse(0, 1, 8'h10, 8'h20, 8'h30, 8'h01, 0, 0, 2'b01);
    pulse(0, 1, 8'hFF, 8'h20, 8'h30, 8'h01, 0, 0, 2'b01);
    chk("R10", "crc_ok", {7'd0, crc_ok}, 8'd1);
    chk("R10", "uncorr", {7'd0, uncorr_blk}, 8'd1);
    chk("R5", "stat2", stat2, 8'hF2);
    repeat (3) @(negedge clk);
    chk("R10", "stat1 hold", stat1, 8'hFF);
    chk("R10", "crc_ok hold", {7'd0, crc_ok}, 8'd1);
    chk("R10", "uncorr hold", {7'd0, uncorr_blk}, 8'd1);
  endtask

  task automatic t_both();
    pulse(1, 1, 8'h05, 8'h06, 8'h07, 8'h00, 0, 0, 2'b10);
    chk("R11", "crc_ok", {7'd0, crc_ok}, 8'd1);
    chk("R11", "uncorr", {7'd0, uncorr_blk}, 8'd0);
    chk("R11", "word_long", {7'd0, word_long}, 8'd1);
    chk("R11", "stat2", stat2, 8'h90);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good_req();
    t_clear();
    t_noreq();
    t_limits();
    t_mode_sync();
    t_sticky();
    t_both();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule